// File: doc/BRIEF.md
# Serial Tuning Word Receiver

This block receives a 40-bit control word for a frequency synthesizer over a three-wire serial link: a word clock, a data line and an update strobe. Each rising edge of the word clock shifts one data bit into an input register, least significant bit first. After forty edges the register holds a full word. A pulse on the update strobe then moves the word into the active control outputs: a 32-bit frequency word, a 5-bit phase word, a reference multiplier enable and a power-down flag.

The word clock, the data line and the strobe are all synchronised into the system clock domain, and edges are detected there. The input register keeps shifting while the device is powered down. When an update clears power-down, a ready output stays low for a programmable number of system clock cycles before normal operation resumes. One bit of the word is reserved and must be zero. A strobe that arrives while it is set does not apply the word and instead sets a sticky error flag.

Top module: `serial_tuning_rx`

## Requirements
- R1: After reset the frequency word, phase word, multiplier enable and power-down outputs are all zero, ready is 1 and the reserved-bit error flag is 0.
- R2: Field positions in the word depend on arrival order. The first bit shifted in is word bit 0. Bits 0..31 are the frequency word, bit 0 being its LSB. Bit 32 is the multiplier enable, bit 33 is reserved, bit 34 is power-down (1 = down), and bits 35..39 are the phase word, bit 35 being its LSB.
- R3: Shifting bits without an update strobe leaves every active output unchanged.
- R4: A rising edge of the update strobe applies the 40 most recently shifted bits to the active outputs.
- R5: If word bit 33 is 1 when the strobe arrives, none of the outputs change and the error flag goes to 1. It stays at 1 until reset.
- R6: While the applied power-down flag is 1, ready is 0.
- R7: The input register accepts a complete new word while the device is powered down, and a later strobe applies that word.
- R8: When an update clears power-down, ready stays 0 for exactly WAKE_CYCLES system clock cycles, counted from the cycle in which the power-down output falls, and then becomes 1.
- R9: An update that keeps power-down at 0 while ready is 1 never drops ready.
- R10: Data is sampled only on rising edges of the word clock. The level of the data line at a falling edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk_in | input | 1 | Serial word clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data, sampled on word clock rising edges |
| strobe_in | input | 1 | Update strobe, acts on its rising edge |
| freq_word | output | 32 | Active frequency word |
| phase_word | output | 5 | Active phase word |
| mult_en | output | 1 | Active reference multiplier enable |
| pwr_down | output | 1 | Active power-down flag |
| ready | output | 1 | High when powered up and the wake-up delay has expired |
| reserved_err | output | 1 | Sticky flag: an update was rejected because the reserved bit was set |

## Verification
The hardest case to reach is the wake-up window. The exact number of cycles between the power-down output falling and ready rising can only be seen if a powered-down state is entered first and then left with a clean word. The bench therefore does this on purpose. It counts system cycles from the strobe onward and records the cycle in which power-down falls and the cycle in which ready rises. Random words with power-down and reserved bits drawn at random add more of these transitions. On every bit the data line is also flipped at the falling word-clock edge, so a design that samples on the wrong edge is caught.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int WORD_BITS  = 40;
    localparam int FREQ_BITS  = 32;
    localparam int PHASE_BITS = 5;
    localparam int MULT_POS   = 32;
    localparam int RSVD_POS   = 33;
    localparam int PD_POS     = 34;
    localparam int PHASE_LSB  = 35;

    typedef struct packed {
        logic [FREQ_BITS-1:0]  freq;
        logic [PHASE_BITS-1:0] phase;
        logic                  mult_en;
        logic                  pwr_down;
    } ctrl_t;
endpackage

// File: rtl/tw_sync_bus.sv
module tw_sync_bus #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/tw_rise_det.sv
module tw_rise_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = lvl & ~st_q.prev;
endmodule

// File: rtl/tw_shift_reg.sv
module tw_shift_reg #(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } sr_st_t;

    sr_st_t st_d, st_q;

    // New bits enter at the top and move down, so after WIDTH shifts
    // the first bit received sits at position 0.
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {bit_in, st_q.sr[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;
endmodule

// File: rtl/tw_apply_ctrl.sv
module tw_apply_ctrl
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [WORD_BITS-1:0] word,
    output ctrl_t                ctrl,
    output logic                 err
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  err;
    } ap_st_t;

    ap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            if (word[RSVD_POS]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.ctrl.freq     = word[FREQ_BITS-1:0];
                st_d.ctrl.mult_en  = word[MULT_POS];
                st_d.ctrl.pwr_down = word[PD_POS];
                st_d.ctrl.phase    = word[PHASE_LSB +: PHASE_BITS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign err  = st_q.err;
endmodule

// File: rtl/tw_wake_timer.sv
module tw_wake_timer #(
    parameter int WAKE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic ready
);
    localparam int CW = (WAKE_CYCLES > 0) ? $clog2(WAKE_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wk_st_t;

    wk_st_t st_d, st_q;

    // Counter is held at LOAD while powered down and runs down once
    // power-down falls; ready requires both conditions clear.
    always_comb begin
        st_d = st_q;
        if (pd) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = !pd && (st_q.cnt == '0);
endmodule

// File: rtl/serial_tuning_rx.sv
module serial_tuning_rx
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wclk_in,
    input  logic        sdata_in,
    input  logic        strobe_in,
    output logic [31:0] freq_word,
    output logic [4:0]  phase_word,
    output logic        mult_en,
    output logic        pwr_down,
    output logic        ready,
    output logic        reserved_err
);
    localparam int IN_W = 3;

    logic [IN_W-1:0]      sync_lvl;
    logic [1:0]           edge_rise;
    logic                 shift_rise;
    logic                 upd_rise;
    logic [WORD_BITS-1:0] shift_word;
    ctrl_t                ctrl;

    // bit 0: word clock, bit 1: data, bit 2: strobe; equal latency keeps
    // data aligned with the clock edge that samples it
    tw_sync_bus #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({strobe_in, sdata_in, wclk_in}),
        .dout (sync_lvl)
    );

    tw_rise_det #(.WIDTH(2)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({sync_lvl[2], sync_lvl[0]}),
        .rise (edge_rise)
    );

    assign shift_rise = edge_rise[0];
    assign upd_rise   = edge_rise[1];

    tw_shift_reg #(.WIDTH(WORD_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_rise),
        .bit_in  (sync_lvl[1]),
        .word    (shift_word)
    );

    tw_apply_ctrl u_apply (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (upd_rise),
        .word (shift_word),
        .ctrl (ctrl),
        .err  (reserved_err)
    );

    tw_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .pd   (ctrl.pwr_down),
        .ready(ready)
    );

    assign freq_word  = ctrl.freq;
    assign phase_word = ctrl.phase;
    assign mult_en    = ctrl.mult_en;
    assign pwr_down   = ctrl.pwr_down;
endmodule

// File: rtl/tw_rx_checker.sv
module tw_rx_checker #(
    parameter int WAKE_CYCLES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_rise,
    input logic [39:0] shift_word,
    input logic [31:0] freq_word,
    input logic [4:0]  phase_word,
    input logic        mult_en,
    input logic        pwr_down,
    input logic        ready,
    input logic        reserved_err
);
    assert_hold_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_rise |=> ($stable(freq_word) && $stable(phase_word) && $stable(mult_en) && $stable(pwr_down)));

    assert_apply_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_rise && !shift_word[33]) |=> (freq_word == $past(shift_word[31:0]) &&
                                           phase_word == $past(shift_word[39:35])));

    assert_reserved_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_rise && shift_word[33]) |=> ($stable(freq_word) && $stable(pwr_down) && reserved_err));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_err |=> reserved_err);

    assert_ready_low_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !ready);

    generate
        if (WAKE_CYCLES > 0) begin : g_wake
            assert_wake_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pwr_down) |-> !ready);
        end
    endgenerate
endmodule

bind serial_tuning_rx tw_rx_checker #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_rise    (upd_rise),
    .shift_word  (shift_word),
    .freq_word   (freq_word),
    .phase_word  (phase_word),
    .mult_en     (mult_en),
    .pwr_down    (pwr_down),
    .ready       (ready),
    .reserved_err(reserved_err)
);

// File: tb/serial_tuning_rx_test.sv
module serial_tuning_rx_test;
    localparam int WAKE = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic        strobe_in = 1'b0;
    logic [31:0] freq_word;
    logic [4:0]  phase_word;
    logic        mult_en;
    logic        pwr_down;
    logic        ready;
    logic        reserved_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] e_freq = '0;
    logic [4:0]  e_phase = '0;
    logic        e_mult = 1'b0;
    logic        e_pd = 1'b0;
    logic        e_err = 1'b0;

    always #4 clk = ~clk;

    serial_tuning_rx #(.SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .wclk_in(wclk_in), .sdata_in(sdata_in),
        .strobe_in(strobe_in), .freq_word(freq_word), .phase_word(phase_word),
        .mult_en(mult_en), .pwr_down(pwr_down), .ready(ready),
        .reserved_err(reserved_err)
    );

    function automatic logic [39:0] mk(input logic [31:0] f, input logic m,
                                       input logic r, input logic p, input logic [4:0] ph);
        return {ph, p, r, m, f};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: data flips to the opposite value at the falling edge
    task automatic send_bit(input logic b);
        @(negedge clk) sdata_in = b;
        repeat (2) @(negedge clk);
        wclk_in = 1'b1;
        repeat (3) @(negedge clk);
        sdata_in = ~b;
        wclk_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [39:0] w);
        for (int i = 0; i < 40; i++) send_bit(w[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " freq"},  64'(freq_word),  64'(e_freq));
        chk({tag, " phase"}, 64'(phase_word), 64'(e_phase));
        chk({tag, " mult"},  64'(mult_en),    64'(e_mult));
        chk({tag, " pd"},    64'(pwr_down),   64'(e_pd));
        chk("R5 err flag",   64'(reserved_err), 64'(e_err));
    endtask

    task automatic do_update(input logic [39:0] w, input string tag);
        logic prev_pd, prev_rdy, wake_exp;
        int t_pd, t_rdy;
        bit saw_low;
        prev_pd  = e_pd;
        prev_rdy = ready;
        if (w[33]) begin
            e_err = 1'b1;
        end else begin
            e_freq = w[31:0]; e_mult = w[32]; e_pd = w[34]; e_phase = w[39:35];
        end
        wake_exp = prev_pd && !e_pd;
        t_pd = -1; t_rdy = -1; saw_low = 1'b0;
        @(negedge clk) strobe_in = 1'b1;
        for (int n = 0; n < WAKE + 20; n++) begin
            @(negedge clk);
            if (n == 3) strobe_in = 1'b0;
            if (!ready) saw_low = 1'b1;
            if (t_pd < 0 && !pwr_down) t_pd = n;
            if (t_rdy < 0 && ready) t_rdy = n;
        end
        check_outputs(tag);
        chk("R6 ready vs power-down", 64'(ready), 64'(!e_pd));
        if (wake_exp) chk("R8 wake cycles", 64'(t_rdy - t_pd), 64'(WAKE));
        if (!prev_pd && !e_pd && prev_rdy) chk("R9 ready never dropped", 64'(saw_low), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] w;
        void'($urandom(32'd7391));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 freq", 64'(freq_word), 0);
        chk("R1 phase", 64'(phase_word), 0);
        chk("R1 mult", 64'(mult_en), 0);
        chk("R1 pd", 64'(pwr_down), 0);
        chk("R1 ready", 64'(ready), 1);
        chk("R1 err", 64'(reserved_err), 0);

        // R2 field layout, R10 rising-edge sampling
        w = mk(32'h1234_5678, 1'b1, 1'b0, 1'b0, 5'h15);
        send_word(w);
        do_update(w, "R2 R10 layout");

        // R3 shifting without strobe changes nothing
        w = mk(32'hCAFE_0001, 1'b0, 1'b0, 1'b0, 5'h0A);
        send_word(w);
        check_outputs("R3 no strobe");

        // R4 strobe applies the pending word
        do_update(w, "R4 apply");

        // R5 reserved bit rejects the word
        w = mk(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 5'h1F);
        send_word(w);
        do_update(w, "R5 reserved");

        // R6 power down
        w = mk(32'h0000_00FF, 1'b0, 1'b0, 1'b1, 5'h03);
        send_word(w);
        do_update(w, "R6 power-down");

        // R7 new word loaded while powered down
        w = mk(32'h8000_0001, 1'b1, 1'b0, 1'b1, 5'h11);
        send_word(w);
        do_update(w, "R7 load in power-down");

        // R8 wake-up delay
        w = mk(32'h0F0F_0F0F, 1'b0, 1'b0, 1'b0, 5'h1E);
        send_word(w);
        do_update(w, "R8 wake");

        // R9 update while already up
        w = mk(32'h7654_3210, 1'b1, 1'b0, 1'b0, 5'h01);
        send_word(w);
        do_update(w, "R9 stay up");

        for (int k = 0; k < 30; k++) begin
            w = {$urandom, $urandom};
            w[33] = (($urandom % 8) == 0);
            w[34] = (($urandom % 3) == 0);
            send_word(w);
            do_update(w, "R4 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule